// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This peripheral timer counts with an 8-bit up-counter. A free-running prescaler divides the peripheral clock, and the count clock is one of eight fixed, unevenly spaced ratios of it. The counter wraps from 0xFF to 0x00, and that wrap is the overflow event.

A mode bit sets what an overflow does. In watchdog mode it latches a watchdog flag and drives a reset request for a fixed number of cycles. In interval mode it latches a separate interval flag, and the interrupt request stays high while that flag is set. Software reaches the counter and the control word through a one-bit register select on a simple write/read port. Software clears a flag by writing 0 to its bit.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the counter reads 0x00 and the control word reads 0x00. In that state the timer is disabled, in interval mode, with select 000 and both flags clear. The interrupt and reset requests are low.
- R2: The counter advances only while the enable bit (control bit 7) is 1. While that bit is 0 it holds its value indefinitely.
- R3: Select codes 0 to 7 in control bits 2..0 pick divisions of 1, 4, 16, 32, 64, 256, 1024 and 4096. In steady state the counter increments exactly once per selected number of clock cycles.
- R4: The counter wraps from 0xFF to 0x00. At divide-by-1, after a counter write of S, the overflow becomes visible 256-S cycles after the write edge.
- R5: In interval mode (control bit 6 = 0), an overflow sets the interval flag at bit 3 and never sets bit 4. The interrupt request is high exactly while bit 3 is set.
- R6: In watchdog mode (control bit 6 = 1), an overflow sets the watchdog flag at bit 4 and never sets bit 3. The reset request goes high on the cycle after the overflow edge and stays high for RST_CYCLES (default 16) cycles.
- R7: A control write of 0 to a flag bit clears that flag. A write of 1 leaves it unchanged and cannot set it. If an overflow falls on the same edge as a clearing write, the flag ends up set.
- R8: A write with select 0 loads the counter and a write with select 1 loads the control word. Reads return the addressed register with no delay, and control bit 5 always reads 0.
- R9: Change the select field while the timer is disabled, then enable the timer. The counter then runs at the newly selected period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 = counter, 1 = control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Interval interrupt request |
| rst_req_o | output | 1 | Watchdog reset request pulse |

## Verification
A wrong prescaler phase or mask shows at once at the counter read port. The gap between two increments differs from the selected division within one division period, which is at most 4096 cycles. A counter or flag fault shows on the wrap: the interrupt or reset request rises at the wrong cycle, or the wrong flag appears in the control read-back, within 256 count periods. A fault in the pulse stretcher shows as a reset request that is too long or too short, within RST_CYCLES cycles after an overflow.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int SEL_W    = 3;
  localparam int EN_BIT   = 7;
  localparam int MODE_BIT = 6;
  localparam int WOVF_BIT = 4;
  localparam int IOVF_BIT = 3;

  function automatic int unsigned div_shift(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0: div_shift = 0;
      3'd1: div_shift = 2;
      3'd2: div_shift = 4;
      3'd3: div_shift = 5;
      3'd4: div_shift = 6;
      3'd5: div_shift = 8;
      3'd6: div_shift = 10;
      default: div_shift = 12;
    endcase
  endfunction
endpackage

// File: rtl/dmt_prescaler.sv
module dmt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [dmt_pkg::SEL_W-1:0] sel_i,
  output logic                      tick_o
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst) pre_cnt <= '0;
    else     pre_cnt <= pre_cnt + 1'b1;
  end

  always_comb begin
    mask   = (PRE_W'(1) << dmt_pkg::div_shift(sel_i)) - PRE_W'(1);
    tick_o = ((pre_cnt & mask) == mask);
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && sel_i != '0) |=> (sel_i == '0 || !tick_o));
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  always_comb ovf_o = en_i && tick_i && !load_i && (cnt_o == '1);

  always_ff @(posedge clk) begin
    if (rst)                cnt_o <= '0;
    else if (load_i)        cnt_o <= load_val_i;
    else if (en_i && tick_i) cnt_o <= cnt_o + 1'b1;
  end

  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !load_i) |=> $stable(cnt_o));
  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> (cnt_o == '0));
endmodule

// File: rtl/dmt_ctrl.sv
module dmt_ctrl #(
  parameter int RST_CYCLES = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_i,
  input  logic [7:0]                wdata_i,
  input  logic                      ovf_i,
  output logic                      en_o,
  output logic                      wd_o,
  output logic [dmt_pkg::SEL_W-1:0] sel_o,
  output logic                      wovf_o,
  output logic                      iovf_o,
  output logic                      rst_req_o,
  output logic [7:0]                ctrl_o
);
  import dmt_pkg::*;
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] rst_cnt;
  logic          ctl_unused;
  assign ctl_unused = wdata_i[5];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= 1'b0;
      wd_o   <= 1'b0;
      sel_o  <= '0;
      wovf_o <= 1'b0;
      iovf_o <= 1'b0;
    end else begin
      if (wr_i) begin
        en_o  <= wdata_i[EN_BIT];
        wd_o  <= wdata_i[MODE_BIT];
        sel_o <= wdata_i[SEL_W-1:0];
      end
      wovf_o <= (ovf_i && wd_o)  || (wovf_o && !(wr_i && !wdata_i[WOVF_BIT]));
      iovf_o <= (ovf_i && !wd_o) || (iovf_o && !(wr_i && !wdata_i[IOVF_BIT]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                rst_cnt <= '0;
    else if (ovf_i && wd_o) rst_cnt <= RW'(RST_CYCLES);
    else if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
  end

  always_comb begin
    rst_req_o = (rst_cnt != '0);
    ctrl_o    = {en_o, wd_o, 1'b0, wovf_o, iovf_o, sel_o};
  end

  // R5
  iovf_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(iovf_o) |-> !$past(wd_o));
  // R6
  wovf_mode_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wovf_o) |-> $past(wd_o));
  // R6
  rst_req_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> $past(ovf_i && wd_o));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer #(
  parameter int CNT_W      = 8,
  parameter int PRE_W      = 12,
  parameter int RST_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_sel,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic                      en, wd, tick, ovf, wovf, iovf;
  logic [dmt_pkg::SEL_W-1:0] sel;
  logic [CNT_W-1:0]          cnt;
  logic [7:0]                ctrl;

  dmt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .sel_i(sel), .tick_o(tick)
  );

  dmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(en), .tick_i(tick),
    .load_i(bus_wr && !bus_sel), .load_val_i(bus_wdata),
    .cnt_o(cnt), .ovf_o(ovf)
  );

  dmt_ctrl #(.RST_CYCLES(RST_CYCLES)) u_ctrl (
    .clk(clk), .rst(rst), .wr_i(bus_wr && bus_sel), .wdata_i(bus_wdata[7:0]),
    .ovf_i(ovf), .en_o(en), .wd_o(wd), .sel_o(sel), .wovf_o(wovf),
    .iovf_o(iovf), .rst_req_o(rst_req_o), .ctrl_o(ctrl)
  );

  always_comb begin
    bus_rdata = bus_sel ? CNT_W'(ctrl) : cnt;
    irq_o     = iovf;
  end

  // R5
  irq_follows_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(ovf && !wd));
endmodule

// File: tb/dual_mode_timer_tb.sv
module dual_mode_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_sel = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_o, rst_req_o;
  int checks = 0;
  int errors = 0;
  localparam int RSTC = 16;

  dual_mode_timer dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  always #4 clk = ~clk;

  function automatic int exp_div(input int s);
    int tbl[8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
    return tbl[s];
  endfunction

  function automatic int exp_ctrl(input int en, input int wd, input int wf, input int inf, input int s);
    return (en << 7) | (wd << 6) | (wf << 4) | (inf << 3) | s;
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(input logic s, input logic [7:0] d);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output int v);
    bus_sel = s; #1; v = bus_rdata;
  endtask

  task automatic run_wrap(input int s, input int wd);
    int first, rhi, v;
    first = -1; rhi = 0;
    wr(1'b1, 8'(exp_ctrl(1, wd, 0, 0, 0)));
    wr(1'b0, 8'(s));
    for (int n = 1; n <= 280; n++) begin
      @(negedge clk); #1;
      if (first < 0 && (irq_o || rst_req_o)) first = n;
      if (rst_req_o) rhi++;
    end
    chk($sformatf("R4 wrap delay from %0d", s), first, 256 - s);
    chk("R6 reset pulse length", rhi, wd ? RSTC : 0);
    chk("R5 irq level", int'(irq_o), wd ? 0 : 1);
    rd(1'b1, v);
    chk(wd ? "R6 flag bits" : "R5 flag bits", v, exp_ctrl(1, wd, wd, 1 - wd, 0));
    @(negedge clk);
    wr(1'b1, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired, all requirements: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, prev, c, s, off;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk("R1 counter", v, 0);
    rd(1'b1, v); chk("R1 control", v, 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 reset request", int'(rst_req_o), 0);
    @(negedge clk);

    // R2 and R8: load while disabled, then hold
    wr(1'b0, 8'h5A);
    repeat (300) @(negedge clk);
    rd(1'b0, v); chk("R2 hold while disabled", v, 8'h5A);
    chk("R2 no request", int'(irq_o | rst_req_o), 0);
    @(negedge clk);
    wr(1'b1, 8'hFF);
    rd(1'b1, v); chk("R8 control readback bit5 zero", v, 8'hC7);
    @(negedge clk);
    wr(1'b1, 8'h00);

    // R4 R5 R6 directed corners then random
    run_wrap(255, 0);
    run_wrap(0, 1);
    for (int i = 0; i < 10; i++) run_wrap(int'($urandom_range(255)), int'($urandom_range(1)));

    // R7 write-1 keeps, write-0 clears
    run_wrap(200, 0);
    wr(1'b1, 8'h80);
    wr(1'b0, 8'h10);
    for (int n = 0; n < 246; n++) @(negedge clk);
    rd(1'b1, v); chk("R7 flag set before clear test", v, 8'h88);
    @(negedge clk);
    wr(1'b1, 8'h98);
    rd(1'b1, v); chk("R7 write 1 keeps flag, cannot set", v, 8'h88);
    chk("R7 irq kept", int'(irq_o), 1);
    @(negedge clk);
    wr(1'b1, 8'h80);
    rd(1'b1, v); chk("R7 write 0 clears", v, 8'h80);
    chk("R7 irq dropped", int'(irq_o), 0);
    @(negedge clk);
    // R7 collision: overflow on the clearing edge
    wr(1'b0, 8'hFE);
    @(negedge clk);
    wr(1'b1, 8'h80);
    rd(1'b1, v); chk("R7 overflow beats clear", v, 8'h88);
    @(negedge clk);
    wr(1'b1, 8'h00);

    // R3 R9 period per select, changed while disabled
    off = int'($urandom_range(7));
    for (int k = 0; k < 8; k++) begin
      s = (k + off) % 8;
      wr(1'b1, 8'(s));
      wr(1'b1, 8'(8'h80 | s));
      rd(1'b0, prev);
      c = 0;
      while (bus_rdata == 8'(prev) && c < 10000) begin @(negedge clk); #1; c++; end
      prev = bus_rdata; c = 0;
      do begin @(negedge clk); #1; c++; end while (bus_rdata == 8'(prev) && c < 10000);
      chk($sformatf("R3 R9 increment period sel %0d", s), c, exp_div(s));
      @(negedge clk);
      wr(1'b1, 8'h00);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule